// File: doc/BRIEF.md
# I2C Byte-Memory Slave

This block is the two-wire bus front end of a small byte-wide memory of 256 locations. It watches the open-drain clock and data lines, recognises bus start and stop events, checks a 7-bit device address, and then either accepts a byte address and one data byte or streams data bytes back to the bus master. It pulls the data line low through a single enable output whenever it acknowledges or drives a zero bit.

One address pointer inside the block serves every access. A write loads it from the byte address and advances it past the byte stored. A read returns the byte the pointer selects and then advances it. A random read is a write that carries only an address, followed by a repeated start and a read. A protect pin makes the upper half of the memory read-only. A write aimed there is turned away at its data byte: the slave withholds the acknowledge for that byte.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data line while the clock is high (START) restarts address reception from any state, including in the middle of a byte. A rising data line while the clock is high (STOP) returns the slave to idle with the data line released.
- R2: The address byte is sent MSB first and laid out as {4'b1010, dev_sel[2:0], rw}, with rw=1 meaning read. Any other value gets no acknowledge, the slave ignores the bus until the next START or STOP, and the pointer is left unchanged.
- R3: A matching address byte and a byte address are each acknowledged by holding the data line low through the ninth clock.
- R4: In a write, the byte after the byte address is stored at that address and acknowledged, and the pointer becomes that address plus one.
- R5: A write stores only one data byte. Further data bytes in the same transfer get no acknowledge and are not stored.
- R6: While wp_in is 1, a data byte aimed at 0x80..0xFF gets no acknowledge, memory is left unchanged, and the pointer stays at the byte address. Addresses 0x00..0x7F stay writable. While wp_in is 0, every address is writable.
- R7: A read without a preceding byte address (current-address read) returns the byte at the pointer and then advances the pointer by one.
- R8: A random read (address-only write, repeated START, read) returns the byte at the given address.
- R9: A master acknowledge after a read byte makes the slave send the next byte. The pointer wraps from 0xFF to 0x00.
- R10: Read data goes out MSB first. After a master NACK the slave releases the data line and drives nothing more until START or STOP. The data line output changes only while the clock is low.
- R11: After reset the data line is released, the pointer is 0 and every memory byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| wp_in | input | 1 | Write protect for the upper half of memory |
| dev_sel | input | 3 | Device-select bits matched against the address byte |
| sda_pull | output | 1 | Data line pull-down enable (1 = drive low) |

## Verification
The acknowledge decision and the memory commit for a write data byte both fall on the same clock-fall detection. In that cycle the protect check and the pointer advance also take effect. The bench provokes this collision by toggling wp_in at random from one transfer to the next, with addresses drawn mostly from around the 0x7F/0x80 boundary and the 0xFF/0x00 wrap. It judges each case twice: it samples the ninth-bit acknowledge against a reference decision, and it reads the location back (and the following one, through the shared pointer) against a reference memory model.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int AW = 8,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          wp_in,
  input  logic [2:0]    dev_sel,
  output logic          sda_pull
);
  localparam int BW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(BW + 1);
  localparam logic [CW-1:0] FULL = CW'(BW);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_ADR, S_ADR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK, S_HOLD
  } st_t;

  st_t            state;
  logic [2:0]     scl_q, sda_q;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  sh, tx;
  logic [AW-1:0]  ptr;
  logic           rw, mack;
  logic [BW-1:0]  mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_c   = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop_c    = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  wire byte_done = scl_fall && (cnt == FULL);
  wire addr_ok   = (sh[7:4] == DEV_CODE) && (sh[3:1] == dev_sel);
  wire wp_hit    = wp_in & ptr[AW-1];
  wire mem_we    = (state == S_WDAT) && byte_done && !wp_hit && !start_c && !stop_c;
  wire [BW-1:0] rd_data = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[ptr] <= sh;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      state    <= S_DEV;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      state    <= S_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        S_DEV, S_ADR, S_WDAT: begin
          if (scl_rise && cnt != FULL) begin
            sh  <= {sh[BW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (state == S_DEV) begin
              if (addr_ok) begin
                rw       <= sh[0];
                sda_pull <= 1'b1;
                state    <= S_DEV_ACK;
              end else begin
                state <= S_HOLD;
              end
            end else if (state == S_ADR) begin
              ptr      <= sh[AW-1:0];
              sda_pull <= 1'b1;
              state    <= S_ADR_ACK;
            end else if (wp_hit) begin
              state <= S_HOLD;
            end else begin
              ptr      <= ptr + 1'b1;
              sda_pull <= 1'b1;
              state    <= S_WDAT_ACK;
            end
          end
        end
        S_DEV_ACK: if (scl_fall) begin
          if (rw) begin
            tx       <= rd_data;
            ptr      <= ptr + 1'b1;
            sda_pull <= ~rd_data[BW-1];
            state    <= S_RDAT;
          end else begin
            sda_pull <= 1'b0;
            state    <= S_ADR;
          end
        end
        S_ADR_ACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          state    <= S_WDAT;
        end
        S_WDAT_ACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          state    <= S_HOLD;
        end
        S_RDAT: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == FULL) begin
              cnt      <= '0;
              sda_pull <= 1'b0;
              state    <= S_RACK;
            end else begin
              tx       <= {tx[BW-2:0], 1'b0};
              sda_pull <= ~tx[BW-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx       <= rd_data;
              ptr      <= ptr + 1'b1;
              sda_pull <= ~rd_data[BW-1];
              state    <= S_RDAT;
            end else begin
              state <= S_HOLD;
            end
          end
        end
        default: ;
      endcase
    end

  // R1
  start_to_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == S_DEV) && !sda_pull);

  // R1
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == S_IDLE) && !sda_pull);

  // R2
  bad_addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_DEV) && byte_done && !addr_ok && !start_c && !stop_c)
      |=> !sda_pull && (state == S_HOLD));

  // R6
  wp_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WDAT) && byte_done && wp_in && ptr[AW-1] && !start_c && !stop_c)
      |=> !sda_pull && $stable(ptr));

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_RACK) && scl_fall && mack && (ptr == '1)) |=> (ptr == '0));

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_s));

endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] dsel = 3'b101;
  logic sda_pull;
  wire sda_line = m_sda & ~sda_pull;

  always #10 clk = ~clk;

  i2c_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .wp_in(wp), .dev_sel(dsel), .sda_pull(sda_pull)
  );

  int checks = 0, errors = 0, pull_bad = 0;
  logic [7:0] mref [256];
  logic [7:0] pref;
  logic pull_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n && (sda_pull !== pull_prev) && m_scl) pull_bad++;
    pull_prev = sda_pull;
  end

  function automatic logic [7:0] devb(input logic rd);
    return {4'b1010, dsel, rd};
  endfunction

  function automatic bit exp_ack(input logic [7:0] a, input logic w);
    return !(w && a[7]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(); m_scl = 1'b1; tick(); m_sda = 1'b0; tick(); m_scl = 1'b0; tick();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(); m_scl = 1'b1; tick(); m_sda = 1'b1; tick();
  endtask

  task automatic wbit(input bit b);
    m_sda = b; tick(); m_scl = 1'b1; tick(); tick(); m_scl = 1'b0; tick();
  endtask

  task automatic rbit(output bit b);
    m_sda = 1'b1; tick(); m_scl = 1'b1; tick(); b = sda_line; tick(); m_scl = 1'b0; tick();
  endtask

  task automatic send(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic recv(input bit mack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(!mack);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic w);
    bit ack, e;
    wp = w;
    bus_start();
    send(devb(1'b0), ack); chk(ack, "R3", "write address ack", ack, 1);
    send(a, ack);          chk(ack, "R3", "byte address ack", ack, 1);
    send(d, ack);
    e = exp_ack(a, w);
    chk(ack == e, e ? "R4" : "R6", "data ack", ack, e);
    bus_stop();
    if (e) begin
      mref[a] = d;
      pref = a + 8'd1;
    end else begin
      pref = a;
    end
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, v);
      chk(v == mref[pref], req, "read data", v, mref[pref]);
      pref = pref + 8'd1;
    end
    tick();
    chk(sda_pull == 1'b0, "R10", "released after nack", sda_pull, 0);
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    bit ack;
    bus_start();
    send(devb(1'b0), ack); chk(ack, "R3", "dummy write ack", ack, 1);
    send(a, ack);          chk(ack, "R3", "dummy addr ack", ack, 1);
    pref = a;
    bus_start();
    send(devb(1'b1), ack); chk(ack, "R8", "read address ack", ack, 1);
    read_bytes(n, req);
  endtask

  task automatic cur_read(input int n, input string req);
    bit ack;
    bus_start();
    send(devb(1'b1), ack); chk(ack, "R7", "current read ack", ack, 1);
    read_bytes(n, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ack, b;
    logic [7:0] v;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) mref[i] = 8'h00;
    pref = 8'h00;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R11", "pull during reset", sda_pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R11", "pull after reset", sda_pull, 0);

    cur_read(1, "R11");
    do_write(8'h10, 8'hA5, 1'b0);
    cur_read(1, "R4");
    rand_read(8'h10, 1, "R8");

    bus_start();
    send({4'b1010, ~dsel, 1'b0}, ack); chk(!ack, "R2", "wrong select nack", ack, 0);
    bus_stop();
    bus_start();
    send({4'b0101, dsel, 1'b1}, ack); chk(!ack, "R2", "wrong code nack", ack, 0);
    for (int i = 0; i < 8; i++) begin
      rbit(b);
      chk(b == 1'b1, "R2", "ignored bus idle", b, 1);
    end
    bus_stop();
    cur_read(1, "R2");

    do_write(8'h80, 8'h3C, 1'b1);
    cur_read(1, "R6");
    do_write(8'h7F, 8'h66, 1'b1);
    rand_read(8'h7F, 2, "R6");
    do_write(8'hC0, 8'h11, 1'b0);
    do_write(8'hC0, 8'h22, 1'b1);
    rand_read(8'hC0, 1, "R6");
    wp = 1'b0;

    bus_start();
    send(devb(1'b0), ack); send(8'h20, ack);
    send(8'h01, ack); chk(ack, "R5", "first data ack", ack, 1);
    send(8'h02, ack); chk(!ack, "R5", "second data nack", ack, 0);
    bus_stop();
    mref[8'h20] = 8'h01;
    rand_read(8'h20, 2, "R5");

    do_write(8'hFF, 8'h5A, 1'b0);
    do_write(8'h00, 8'hC3, 1'b0);
    do_write(8'hFE, 8'h77, 1'b0);
    rand_read(8'hFE, 3, "R9");
    cur_read(2, "R9");

    bus_start();
    send(devb(1'b1), ack);
    recv(1'b0, v);
    chk(v == mref[pref], "R10", "msb-first data", v, mref[pref]);
    pref = pref + 8'd1;
    for (int i = 0; i < 9; i++) begin
      rbit(b);
      chk(b == 1'b1, "R10", "no drive after nack", b, 1);
    end
    bus_stop();

    bus_start();
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    rand_read(8'h10, 1, "R1");
    chk(sda_pull == 1'b0, "R1", "released after stop", sda_pull, 0);

    for (int it = 0; it < 70; it++) begin
      logic [7:0] a, d;
      logic w;
      int op;
      op = int'($urandom % 4);
      w  = 1'($urandom % 2);
      d  = 8'($urandom);
      case ($urandom % 3)
        0: a = 8'($urandom);
        1: a = 8'h7E + 8'($urandom % 4);
        default: a = 8'hFE + 8'($urandom % 3);
      endcase
      case (op)
        0, 1: do_write(a, d, w);
        2: rand_read(a, 1 + int'($urandom % 3), "R8");
        default: cur_read(1 + int'($urandom % 3), "R7");
      endcase
    end

    chk(pull_bad == 0, "R10", "pull changed with scl high", pull_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule